// File: doc/BRIEF.md
# Windowed NFA State-Element Array

The block runs a homogeneous nondeterministic finite automaton over a stream of 8-bit symbols, taking one symbol per clock. It is built from a row of identical state elements. Each element holds a one-bit acceptance entry for each of the 256 symbol values, a flag that lets it fire with no predecessor (an entry point), a flag that makes it a reporting state, and one enable bit for each neighbour inside a fixed window centred on itself. An element becomes active on a symbol when its acceptance entry for that symbol is set and either its entry-point flag is set or an enabled neighbour was active after the previous symbol. Any number of elements may be active at once. This is how an automaton tracks several partial matches in parallel.

The surrounding system writes the automaton into the array by shifting configuration bits serially through a chain that runs through every element. The same chain returns the previous contents at its far end, so a full pass of the chain can read the configuration back, or rotate it back in unchanged. While the chain shifts, the automaton state is frozen. A synchronous clear empties the active set and leaves the configuration as it is.

Top module: `nfa_se_array`

## Requirements
- R1: After reset, all bits of `active`, all bits of `report` and `cfg_out` are 0.
- R2: An element whose entry-point flag (per-element configuration bit 256) is set goes active one clock after a valid symbol whose acceptance entry (configuration bit equal to the symbol value) is set. It stays inactive if that entry is clear.
- R3: An element with entry-point flag clear goes active on a valid accepted symbol only if a neighbour at offset k was active and the element's edge enable for k (configuration bit 258+k+HALF, HALF=(FANOUT-1)/2) is set. A cleared enable blocks the neighbour.
- R4: The neighbour window spans offsets -HALF..+HALF, including backward edges from higher-numbered elements. Positions outside 0..N_ELEM-1 contribute nothing, with no wrap-around.
- R5: Several elements are active at once. With elements 0..4 configured for "ababc" (0 an entry point on 'a', each following element accepting the next letter from its predecessor at offset -1), the inputs a,b,a,b,a,b,c give active sets {0},{1},{0,2},{1,3},{0,2},{1,3},{4}.
- R6: `report` equals `active` masked by each element's report flag (configuration bit 257). It is never set for an inactive element.
- R7: With `in_valid` low and `clear` low, `active` holds its value whatever `in_sym` carries.
- R8: `clear` empties `active` on the next clock and leaves the configuration intact.
- R9: While `cfg_shift_en` is high, each clock moves every configuration bit one place along the chain (element i bit b to bit b+1, bit 266 to element i+1 bit 0, `cfg_in` into element 0 bit 0, `cfg_out` showing element N_ELEM-1 bit 266), and `active` is held. With `cfg_shift_en` low, the chain and `cfg_out` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Symbol on `in_sym` is consumed this cycle |
| in_sym | input | 8 | Input symbol |
| clear | input | 1 | Synchronous clear of the active set |
| cfg_shift_en | input | 1 | Shift the configuration chain one place |
| cfg_in | input | 1 | Serial configuration input |
| cfg_out | output | 1 | Serial configuration output (last chain bit) |
| active | output | N_ELEM | Active set after the last consumed symbol |
| report | output | N_ELEM | Active elements whose report flag is set |

## Verification
Four properties are checked on every cycle: the active set is frozen when no symbol is consumed or the chain is shifting, a clear empties it on the next clock, the serial output is quiet while the chain is idle, and no report line is raised by an inactive element. The rest of the block's behaviour can only be shown by the bench's scenarios. This covers the activation rule itself, the limits of the neighbour window at the array edges, the parallel tracking of overlapping "ababc" prefixes, and the round trip of a full configuration through the chain.

// File: rtl/nfa_se_pkg.sv
package nfa_se_pkg;
  localparam int SYM_W      = 8;
  localparam int NSYM       = 1 << SYM_W;
  localparam int START_IDX  = NSYM;
  localparam int REPORT_IDX = NSYM + 1;
  localparam int EDGE_IDX   = NSYM + 2;

  function automatic int cfg_width(input int fanout);
    return EDGE_IDX + fanout;
  endfunction
endpackage

// File: rtl/nfa_se_cfg.sv
module nfa_se_cfg #(
  parameter int CFG_W = 267
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic             ser_out,
  output logic [CFG_W-1:0] cfg_q
);
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (shift_en) cfg_d = {cfg_q[CFG_W-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign ser_out = cfg_q[CFG_W-1];
endmodule

// File: rtl/nfa_se_core.sv
module nfa_se_core #(
  parameter int FANOUT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              clr,
  input  logic              match_hit,
  input  logic              start_flag,
  input  logic [FANOUT-1:0] edge_en,
  input  logic [FANOUT-1:0] nbr_act,
  output logic              act_q
);
  logic act_d;
  logic fed;

  always_comb begin
    fed   = start_flag | (|(edge_en & nbr_act));
    act_d = act_q;
    if (clr)         act_d = 1'b0;
    else if (upd_en) act_d = match_hit & fed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end
endmodule

// File: rtl/nfa_se_array.sv
module nfa_se_array
  import nfa_se_pkg::*;
#(
  parameter int N_ELEM = 8,
  parameter int FANOUT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SYM_W-1:0]  in_sym,
  input  logic              clear,
  input  logic              cfg_shift_en,
  input  logic              cfg_in,
  output logic              cfg_out,
  output logic [N_ELEM-1:0] active,
  output logic [N_ELEM-1:0] report
);
  localparam int HALF  = (FANOUT - 1) / 2;
  localparam int CFG_W = cfg_width(FANOUT);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [N_ELEM:0]   chain;
  logic [N_ELEM-1:0] act_vec;
  logic [N_ELEM-1:0] rep_vec;
  logic              upd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign upd_en   = in_valid & ~cfg_shift_en;
  assign chain[0] = cfg_in;

  for (genvar i = 0; i < N_ELEM; i++) begin : g_elem
    logic [CFG_W-1:0]  cfg_q;
    logic [NSYM-1:0]   match_tbl;
    logic [FANOUT-1:0] nbr_act;

    nfa_se_cfg #(.CFG_W(CFG_W)) cfg_i (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .shift_en (cfg_shift_en),
      .ser_in   (chain[i]),
      .ser_out  (chain[i+1]),
      .cfg_q    (cfg_q)
    );

    for (genvar j = 0; j < FANOUT; j++) begin : g_nbr
      localparam int SRC = i + j - HALF;
      if (SRC >= 0 && SRC < N_ELEM) begin : g_in
        assign nbr_act[j] = act_vec[SRC];
      end else begin : g_out
        assign nbr_act[j] = 1'b0;
      end
    end

    assign match_tbl  = cfg_q[NSYM-1:0];
    assign rep_vec[i] = cfg_q[REPORT_IDX];

    nfa_se_core #(.FANOUT(FANOUT)) core_i (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .upd_en     (upd_en),
      .clr        (clear),
      .match_hit  (match_tbl[in_sym]),
      .start_flag (cfg_q[START_IDX]),
      .edge_en    (cfg_q[EDGE_IDX +: FANOUT]),
      .nbr_act    (nbr_act),
      .act_q      (act_vec[i])
    );
  end

  assign cfg_out = chain[N_ELEM];
  assign active  = act_vec;
  assign report  = act_vec & rep_vec;
endmodule

// File: rtl/nfa_se_array_chk.sv
module nfa_se_array_chk #(
  parameter int N_ELEM = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              clear,
  input logic              cfg_shift_en,
  input logic              cfg_out,
  input logic [N_ELEM-1:0] active,
  input logic [N_ELEM-1:0] report
);
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clear) |=> $stable(active));

  assert_shift_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_shift_en && !clear) |=> $stable(active));

  assert_chain_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_shift_en |=> $stable(cfg_out));

  assert_clear_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (active == '0));

  assert_report_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((report & ~active) == '0));
endmodule

bind nfa_se_array nfa_se_array_chk #(.N_ELEM(N_ELEM)) chk_i (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .in_valid     (in_valid),
  .clear        (clear),
  .cfg_shift_en (cfg_shift_en),
  .cfg_out      (cfg_out),
  .active       (active),
  .report       (report)
);

// File: tb/nfa_se_array_tb_top.sv
module nfa_se_array_tb_top;
  localparam int N     = 8;
  localparam int FAN   = 9;
  localparam int HALF  = (FAN - 1) / 2;
  localparam int CW    = 256 + 2 + FAN;
  localparam int TOTAL = N * CW;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [7:0]   in_sym;
  logic         clear;
  logic         cfg_shift_en;
  logic         cfg_in;
  logic         cfg_out;
  logic [N-1:0] active;
  logic [N-1:0] report;

  logic [TOTAL-1:0] cfgv;
  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  nfa_se_array #(.N_ELEM(N), .FANOUT(FAN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym(in_sym),
    .clear(clear), .cfg_shift_en(cfg_shift_en), .cfg_in(cfg_in),
    .cfg_out(cfg_out), .active(active), .report(report)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_match(input int e, input logic [7:0] s);
    cfgv[e*CW + int'(s)] = 1'b1;
  endtask
  task automatic cfg_start(input int e);
    cfgv[e*CW + 256] = 1'b1;
  endtask
  task automatic cfg_report(input int e);
    cfgv[e*CW + 257] = 1'b1;
  endtask
  task automatic cfg_edge(input int e, input int k);
    cfgv[e*CW + 258 + k + HALF] = 1'b1;
  endtask

  task automatic load_chain();
    for (int t = TOTAL - 1; t >= 0; t--) begin
      cfg_shift_en = 1'b1;
      cfg_in       = cfgv[t];
      @(negedge clk);
    end
    cfg_shift_en = 1'b0;
    cfg_in       = 1'b0;
  endtask

  // full pass that compares cfg_out and feeds it back in
  task automatic rotate_chain(input string req, input logic v, input logic [7:0] s);
    int bad = 0;
    in_valid = v;
    in_sym   = s;
    for (int t = 0; t < TOTAL; t++) begin
      if (cfg_out !== cfgv[TOTAL-1-t]) bad++;
      cfg_shift_en = 1'b1;
      cfg_in       = cfgv[TOTAL-1-t];
      @(negedge clk);
    end
    cfg_shift_en = 1'b0;
    in_valid     = 1'b0;
    check(req, 64'(bad), 64'd0);
  endtask

  task automatic feed(input logic [7:0] s);
    in_sym   = s;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 active", 64'(active), 64'd0);
    check("R1 report", 64'(report), 64'd0);
    check("R1 cfg_out", 64'(cfg_out), 64'd0);
  endtask

  task automatic t_ababc();
    cfgv = '0;
    cfg_start(0); cfg_match(0, "a");
    cfg_match(1, "b"); cfg_edge(1, -1);
    cfg_match(2, "a"); cfg_edge(2, -1);
    cfg_match(3, "b"); cfg_edge(3, -1);
    cfg_match(4, "c"); cfg_edge(4, -1); cfg_report(4);
    load_chain();
    check("R9 first bit at cfg_out", 64'(cfg_out), 64'(cfgv[TOTAL-1]));
    rotate_chain("R9 readback", 1'b0, 8'h00);
    feed("a"); check("R2 R5 step a", 64'(active), 64'h01);
    feed("b"); check("R3 R5 step ab", 64'(active), 64'h02);
    feed("a"); check("R5 step aba", 64'(active), 64'h05);
    feed("b"); check("R5 step abab", 64'(active), 64'h0A);
    check("R6 no report yet", 64'(report), 64'h00);
    feed("a"); check("R5 step ababa", 64'(active), 64'h05);
    feed("b"); check("R5 step ababab", 64'(active), 64'h0A);
    feed("c"); check("R5 step abababc", 64'(active), 64'h10);
    check("R6 report accept", 64'(report), 64'h10);
    feed("z"); check("R2 miss empties", 64'(active), 64'h00);
  endtask

  task automatic t_hold();
    feed("a");
    in_sym = "b";
    repeat (3) @(negedge clk);
    check("R7 hold with in_valid low", 64'(active), 64'h01);
    feed("b"); check("R7 resume after hold", 64'(active), 64'h02);
  endtask

  task automatic t_clear();
    clear = 1'b1; in_valid = 1'b1; in_sym = "a";
    @(negedge clk);
    clear = 1'b0; in_valid = 1'b0;
    check("R8 clear empties", 64'(active), 64'h00);
    feed("a"); check("R8 config survives clear", 64'(active), 64'h01);
  endtask

  task automatic t_shift_freeze();
    rotate_chain("R9 rotate keeps config", 1'b1, "b");
    check("R9 active frozen in shift", 64'(active), 64'h01);
    feed("b"); check("R9 config intact after rotate", 64'(active), 64'h02);
  endtask

  task automatic t_window();
    clear = 1'b1; @(negedge clk); clear = 1'b0;
    cfgv = '0;
    cfg_start(2); cfg_match(2, "q");
    cfg_start(7); cfg_match(7, "q");
    cfg_match(6, "r"); cfg_edge(6, -4); cfg_report(6);
    cfg_match(0, "r"); cfg_edge(0, 2); cfg_edge(0, -1);
    cfg_match(1, "r"); cfg_edge(1, -2); cfg_report(1);
    cfg_match(3, "r"); cfg_edge(3, 1);
    load_chain();
    feed("q");
    check("R2 two entry points", 64'(active), 64'h84);
    check("R6 no flag no report", 64'(report), 64'h00);
    feed("r");
    check("R3 R4 window edges and no wrap", 64'(active), 64'h41);
    check("R6 report masked", 64'(report), 64'h40);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sym = 8'h00; clear = 1'b0;
    cfg_shift_en = 1'b0; cfg_in = 1'b0; cfgv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ababc();
    t_hold();
    t_clear();
    t_shift_freeze();
    t_window();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule